// File: doc/BRIEF.md
# Indirect MMD Register Window

This block opens a two-register window through which a Clause 22 management interface reaches a larger MMD register space. One register, at Clause 22 offset 0xD, holds an access command and a device number. The other, at offset 0xE, carries either the target address inside the selected device or the data stored at that address, depending on the command. The block takes already-decoded Clause 22 register reads and writes. It drives a single-cycle internal port that serves two MMD register banks: the vendor bank (device 31) and MMD1 (device 1).

Each supported device has its own 16-bit address pointer. In the two post-increment modes, the pointer advances by one after a data transfer, so a run of consecutive registers can be walked without rewriting the address. An access that names any other device number is dropped.

Top module: `mmd_window_bridge`

## Requirements
- R1: A synchronous reset clears the command, the device number and both address pointers to 0. After reset, a read of offset 0xD returns 0x0000, and a read of offset 0xE in address mode returns 0x0000 for either device.
- R2: A write to offset 0xD stores bits 15:14 as the command and bits 4:0 as the device number. A read of 0xD returns them in the same positions, with bits 13:5 always 0.
- R3: With command 00, a write to 0xE loads the pointer of the selected device only, and a read of 0xE returns that pointer. The internal port stays idle.
- R4: With command 01, a write to 0xE pulses the port write enable for that cycle, with the address equal to the pointer and the write data equal to the Clause 22 write data. The pointer does not change.
- R5: With any data command, a read of 0xE pulses the port read enable and returns the port read data on the Clause 22 read data in the same cycle.
- R6: With command 10, every data read or write of 0xE advances the selected pointer by one, effective on the next cycle.
- R7: With command 11, a data write advances the selected pointer by one, and a data read leaves it unchanged.
- R8: Pointer advance wraps from 0xFFFF to 0x0000.
- R9: When the device number is neither 31 nor 1, an access to 0xE drives no port enable, changes no pointer and reads as 0x0000.
- R10: The bank select output is 1 for device 31 and 0 for device 1 during every port access.
- R11: Reads and writes of any Clause 22 offset other than 0xD and 0xE change nothing and read as 0x0000. The Clause 22 read data is 0x0000 whenever no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| c22_wr | input | 1 | Decoded Clause 22 register write strobe |
| c22_rd | input | 1 | Decoded Clause 22 register read strobe |
| c22_reg | input | 5 | Clause 22 register offset of the access |
| c22_wdata | input | 16 | Clause 22 write data |
| c22_rdata | output | 16 | Clause 22 read data, combinational |
| mmd_addr | output | 16 | Internal port address (pointer of the selected device) |
| mmd_wdata | output | 16 | Internal port write data |
| mmd_we | output | 1 | Internal port write enable |
| mmd_re | output | 1 | Internal port read enable |
| mmd_sel | output | 1 | Bank select: 1 = vendor bank, 0 = MMD1 |
| mmd_rdata | input | 16 | Internal port read data |

## Verification
The read data, the port enables, the address and the bank select all respond in the same cycle as the Clause 22 strobe. The bench drives each access on a falling edge and compares these outputs 2 ns later, well before the next rising edge. A pointer change from a load or a post-increment becomes visible only after the following rising edge. The scoreboard therefore expects the new address on the next queued access, which lets back-to-back reads and writes check the increment and the wrap one cycle apart.

// File: rtl/mmd_window_bridge.sv
module mmd_window_bridge #(
  parameter int DW = 16,
  parameter int RW = 5,
  parameter logic [RW-1:0] CTRL_REG = 5'h0D,
  parameter logic [RW-1:0] DATA_REG = 5'h0E,
  parameter logic [4:0] DEV_VND = 5'h1F,
  parameter logic [4:0] DEV_STD = 5'h01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          c22_wr,
  input  logic          c22_rd,
  input  logic [RW-1:0] c22_reg,
  input  logic [DW-1:0] c22_wdata,
  output logic [DW-1:0] c22_rdata,
  output logic [DW-1:0] mmd_addr,
  output logic [DW-1:0] mmd_wdata,
  output logic          mmd_we,
  output logic          mmd_re,
  output logic          mmd_sel,
  input  logic [DW-1:0] mmd_rdata
);
  localparam int PADW = DW - 7;

  logic [1:0]    cmd;
  logic [4:0]    devad;
  logic [DW-1:0] ptr_vnd, ptr_std;

  wire hit_ctrl  = c22_reg == CTRL_REG;
  wire hit_data  = c22_reg == DATA_REG;
  wire rd_op     = c22_rd & ~c22_wr;
  wire dev_vnd   = devad == DEV_VND;
  wire dev_ok    = dev_vnd | (devad == DEV_STD);
  wire data_mode = cmd != 2'b00;

  wire [DW-1:0] cur_ptr = dev_vnd ? ptr_vnd : ptr_std;

  assign mmd_addr  = dev_ok ? cur_ptr : '0;
  assign mmd_sel   = dev_vnd;
  assign mmd_wdata = c22_wdata;
  assign mmd_we    = c22_wr & hit_data & data_mode & dev_ok;
  assign mmd_re    = rd_op & hit_data & data_mode & dev_ok;

  wire bump     = (cmd == 2'b10 & (mmd_we | mmd_re)) | (cmd == 2'b11 & mmd_we);
  wire ptr_load = c22_wr & hit_data & ~data_mode & dev_ok;
  wire ptr_upd  = ptr_load | bump;
  wire [DW-1:0] ptr_next = ptr_load ? c22_wdata : cur_ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd     <= '0;
      devad   <= '0;
      ptr_vnd <= '0;
      ptr_std <= '0;
    end else begin
      if (c22_wr & hit_ctrl) begin
        cmd   <= c22_wdata[DW-1 -: 2];
        devad <= c22_wdata[4:0];
      end
      if (ptr_upd & dev_vnd) ptr_vnd <= ptr_next;
      if (ptr_upd & ~dev_vnd) ptr_std <= ptr_next;
    end
  end

  always_comb begin
    c22_rdata = '0;
    if (rd_op) begin
      if (hit_ctrl)
        c22_rdata = {cmd, {PADW{1'b0}}, devad};
      else if (hit_data & dev_ok)
        c22_rdata = data_mode ? mmd_rdata : cur_ptr;
    end
  end
endmodule

// File: rtl/mmd_window_bridge_chk.sv
module mmd_window_bridge_chk #(
  parameter int DW = 16,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          c22_wr,
  input logic          c22_rd,
  input logic [RW-1:0] c22_reg,
  input logic [DW-1:0] c22_wdata,
  input logic [DW-1:0] c22_rdata,
  input logic [DW-1:0] mmd_addr,
  input logic [DW-1:0] mmd_wdata,
  input logic          mmd_we,
  input logic          mmd_re,
  input logic          mmd_sel,
  input logic [1:0]    cmd,
  input logic [4:0]    devad
);
  wire good_dev = (devad == 5'd31) || (devad == 5'd1);
  wire on_data  = c22_reg == 5'h0E;
  wire on_win   = (c22_reg == 5'h0D) || on_data;

  assert_wr_path_R4: assert property (@(posedge clk) disable iff (rst)
    mmd_we |-> (c22_wr && on_data && mmd_wdata == c22_wdata));

  assert_mode01_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mmd_we && cmd == 2'b01) |=> $stable(mmd_addr));

  assert_mode10_step_R6: assert property (@(posedge clk) disable iff (rst)
    ((mmd_we || mmd_re) && cmd == 2'b10) |=> (mmd_addr == DW'($past(mmd_addr) + 1'b1)));

  assert_mode11_rdhold_R7: assert property (@(posedge clk) disable iff (rst)
    (mmd_re && cmd == 2'b11) |=> $stable(mmd_addr));

  assert_bad_dev_drop_R9: assert property (@(posedge clk) disable iff (rst)
    ((c22_wr || c22_rd) && on_data && !good_dev) |-> (!mmd_we && !mmd_re && c22_rdata == '0));

  assert_bank_sel_R10: assert property (@(posedge clk) disable iff (rst)
    (mmd_we || mmd_re) |-> (mmd_sel == (devad == 5'd31)));

  assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (rst)
    (c22_rd && !c22_wr && c22_reg == 5'h0D) |-> (c22_rdata[DW-3:5] == '0));

  assert_other_reg_R11: assert property (@(posedge clk) disable iff (rst)
    ((c22_wr || c22_rd) && !on_win) |-> (!mmd_we && !mmd_re && c22_rdata == '0));

  assert_one_enable_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mmd_we, mmd_re}));
endmodule

bind mmd_window_bridge mmd_window_bridge_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .c22_wr(c22_wr), .c22_rd(c22_rd), .c22_reg(c22_reg),
  .c22_wdata(c22_wdata), .c22_rdata(c22_rdata), .mmd_addr(mmd_addr),
  .mmd_wdata(mmd_wdata), .mmd_we(mmd_we), .mmd_re(mmd_re), .mmd_sel(mmd_sel),
  .cmd(cmd), .devad(devad)
);

// File: tb/sim_mmd_window_bridge.sv
`timescale 1ns/1ps
module sim_mmd_window_bridge;
  logic clk = 0, rst = 1;
  logic c22_wr = 0, c22_rd = 0;
  logic [4:0] c22_reg = '0;
  logic [15:0] c22_wdata = '0;
  logic [15:0] c22_rdata, mmd_addr, mmd_wdata, mmd_rdata;
  logic mmd_we, mmd_re, mmd_sel;

  always #5 clk = ~clk;

  function automatic logic [15:0] bank_fn(input logic s, input logic [15:0] a);
    return a ^ (s ? 16'hA55A : 16'h3CC3);
  endfunction
  assign mmd_rdata = bank_fn(mmd_sel, mmd_addr);

  mmd_window_bridge u0 (
    .clk(clk), .rst(rst), .c22_wr(c22_wr), .c22_rd(c22_rd), .c22_reg(c22_reg),
    .c22_wdata(c22_wdata), .c22_rdata(c22_rdata), .mmd_addr(mmd_addr),
    .mmd_wdata(mmd_wdata), .mmd_we(mmd_we), .mmd_re(mmd_re), .mmd_sel(mmd_sel),
    .mmd_rdata(mmd_rdata)
  );

  typedef struct {
    logic [15:0] rdata;
    bit          port;
    bit          we, re, sel;
    logic [15:0] addr, wdata;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, failures = 0;
  bit done = 0;

  logic [1:0]  m_cmd = 0;
  logic [4:0]  m_dev = 0;
  logic [15:0] m_ptr [2] = '{16'h0, 16'h0};

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input bit r, input logic [4:0] rg, input logic [15:0] d, input string tag);
    exp_t e;
    bit dok, vi;
    e.rdata = 0; e.port = 0; e.we = 0; e.re = 0; e.sel = 0; e.addr = 0; e.wdata = 0; e.tag = tag;
    dok = (m_dev == 5'd31) || (m_dev == 5'd1);
    vi  = (m_dev == 5'd31);
    if (rg == 5'h0D) begin
      if (r && !w) e.rdata = {m_cmd, 9'b0, m_dev};
      if (w) begin m_cmd = d[15:14]; m_dev = d[4:0]; end
    end else if (rg == 5'h0E && dok) begin
      if (m_cmd == 2'b00) begin
        if (w) m_ptr[vi] = d;
        else if (r) e.rdata = m_ptr[vi];
      end else begin
        e.port = 1; e.addr = m_ptr[vi]; e.sel = vi; e.we = w; e.re = r && !w; e.wdata = d;
        if (e.re) e.rdata = bank_fn(vi, m_ptr[vi]);
        if ((m_cmd == 2'b10 && (w || r)) || (m_cmd == 2'b11 && w)) m_ptr[vi] = m_ptr[vi] + 16'd1;
      end
    end
    @(negedge clk);
    c22_wr = w; c22_rd = r; c22_reg = rg; c22_wdata = d;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    c22_wr = 0; c22_rd = 0; c22_reg = 5'h00; c22_wdata = 16'h0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    c22_wr = 0; c22_rd = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    m_cmd = 0; m_dev = 0; m_ptr[0] = 0; m_ptr[1] = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #2;
      if (!rst && (c22_wr || c22_rd)) begin
        if (sb.size() == 0) begin
          check(0, "scoreboard empty", 40'h0, 40'h0);
        end else begin
          e = sb.pop_front();
          check(c22_rdata == e.rdata, {e.tag, " rdata"}, {24'h0, c22_rdata}, {24'h0, e.rdata});
          if (e.port)
            check({mmd_we, mmd_re, mmd_sel, mmd_addr, mmd_wdata} == {e.we, e.re, e.sel, e.addr, e.wdata},
                  {e.tag, " port"}, {5'h0, mmd_we, mmd_re, mmd_sel, mmd_addr, mmd_wdata},
                  {5'h0, e.we, e.re, e.sel, e.addr, e.wdata});
          else
            check({mmd_we, mmd_re} == 2'b00, {e.tag, " port idle"}, {38'h0, mmd_we, mmd_re}, 40'h0);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin : stim
    do_reset();
    acc(0, 1, 5'h0D, 16'h0, "R1 ctrl after reset");
    acc(1, 0, 5'h0D, 16'h0001, "R1 select MMD1");
    acc(0, 1, 5'h0E, 16'h0, "R1 MMD1 pointer after reset");
    acc(1, 0, 5'h0D, 16'h001F, "R1 select vendor");
    acc(0, 1, 5'h0E, 16'h0, "R1 vendor pointer after reset");
    acc(1, 0, 5'h0D, 16'hFFFF, "R2 write all ones");
    acc(0, 1, 5'h0D, 16'h0, "R2 reserved bits zero");
    acc(1, 0, 5'h0D, 16'h001F, "R3 addr mode vendor");
    acc(1, 0, 5'h0E, 16'h1234, "R3 load vendor pointer");
    acc(1, 0, 5'h0D, 16'h0001, "R3 addr mode MMD1");
    acc(1, 0, 5'h0E, 16'h0040, "R3 load MMD1 pointer");
    acc(0, 1, 5'h0E, 16'h0, "R3 read MMD1 pointer");
    acc(1, 0, 5'h0D, 16'h001F, "R3 back to vendor");
    acc(0, 1, 5'h0E, 16'h0, "R3 vendor pointer kept");
    acc(1, 0, 5'h0D, 16'h401F, "R4 mode01 vendor");
    acc(1, 0, 5'h0E, 16'hBEEF, "R4 R10 write no inc");
    acc(1, 0, 5'h0E, 16'hCAFE, "R4 second write same addr");
    acc(0, 1, 5'h0E, 16'h0, "R5 R10 same-cycle read");
    acc(1, 0, 5'h0D, 16'h8001, "R6 mode10 MMD1");
    acc(0, 1, 5'h0E, 16'h0, "R6 read at 0x40");
    acc(0, 1, 5'h0E, 16'h0, "R6 read at 0x41");
    acc(1, 0, 5'h0E, 16'h5555, "R6 R10 write at 0x42");
    acc(0, 1, 5'h0E, 16'h0, "R6 read at 0x43");
    acc(1, 0, 5'h0D, 16'hC01F, "R7 mode11 vendor");
    acc(0, 1, 5'h0E, 16'h0, "R7 read no inc");
    acc(0, 1, 5'h0E, 16'h0, "R7 read again same addr");
    acc(1, 0, 5'h0E, 16'h1111, "R7 write inc");
    acc(0, 1, 5'h0E, 16'h0, "R7 read after write inc");
    acc(1, 0, 5'h0D, 16'h001F, "R8 addr mode vendor");
    acc(1, 0, 5'h0E, 16'hFFFF, "R8 load top address");
    acc(1, 0, 5'h0D, 16'h801F, "R8 mode10 vendor");
    acc(0, 1, 5'h0E, 16'h0, "R8 read at 0xFFFF");
    acc(0, 1, 5'h0E, 16'h0, "R8 read after wrap");
    acc(1, 0, 5'h0D, 16'h001F, "R8 addr mode");
    acc(0, 1, 5'h0E, 16'h0, "R8 pointer is 1");
    acc(1, 0, 5'h0D, 16'h4005, "R9 mode01 device 5");
    acc(1, 0, 5'h0E, 16'h9999, "R9 write dropped");
    acc(0, 1, 5'h0E, 16'h0, "R9 read zero");
    acc(1, 0, 5'h0D, 16'h0005, "R9 addr mode device 5");
    acc(1, 0, 5'h0E, 16'h7777, "R9 pointer write dropped");
    acc(0, 1, 5'h0E, 16'h0, "R9 pointer read zero");
    acc(1, 0, 5'h0D, 16'h0001, "R9 back to MMD1");
    acc(0, 1, 5'h0E, 16'h0, "R9 MMD1 pointer untouched");
    acc(1, 0, 5'h0D, 16'h001F, "R9 back to vendor");
    acc(0, 1, 5'h0E, 16'h0, "R9 vendor pointer untouched");
    acc(1, 0, 5'h10, 16'hFFFF, "R11 write other reg");
    acc(0, 1, 5'h10, 16'h0, "R11 read other reg zero");
    acc(0, 1, 5'h0D, 16'h0, "R11 ctrl unchanged");
    acc(0, 1, 5'h0E, 16'h0, "R11 pointer unchanged");
    idle();
    @(negedge clk); #2;
    check(c22_rdata == 16'h0, "R11 idle rdata zero", {24'h0, c22_rdata}, 40'h0);
    acc(1, 0, 5'h0D, 16'hC001, "R1 set state before reset");
    idle();
    do_reset();
    acc(0, 1, 5'h0D, 16'h0, "R1 ctrl cleared by reset");
    acc(1, 0, 5'h0D, 16'h001F, "R1 select vendor");
    acc(0, 1, 5'h0E, 16'h0, "R1 vendor pointer cleared");
    acc(1, 0, 5'h0D, 16'h0001, "R1 select MMD1");
    acc(0, 1, 5'h0E, 16'h0, "R1 MMD1 pointer cleared");
    idle();
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", 40'(sb.size()), 40'h0);
    finish_run();
  end
endmodule